// File: doc/BRIEF.md
# Codec Serial Port with Frame Sync

This block is the slave-side serial port of a codec that trades 16-bit words with a host signal processor. It runs entirely on the master clock (`mclk`). From that clock it derives a serial clock `sclk` through two cascaded power-of-two dividers and a final toggle stage. Transmit words leave on `sdo` most significant bit first, and each word is announced by a one-bit-wide frame sync pulse on `sfs`. Receive words arrive on `sdi` and are announced the same way on `sdifs`. The block changes its outputs when `sclk` rises and samples its inputs when `sclk` falls, so the host can use the opposite edge of each.

The host side of the chip writes transmit words through a one-deep holding register. A word written while a transfer is in progress waits until the current word has gone out. Each completed receive word is presented on `rx_word` together with a one-cycle strobe.

The asynchronous enable pin `port_en` passes through a two-flop synchronizer and then gates the whole port. While it is low, the port behaves as follows:
- `sclk` is held low.
- The output enables `sdo_oe` and `sfs_oe` drop; the pad drivers outside the block float the pins when these enables are low.
- The serial inputs are ignored.

The holding register and the last received word survive a disable, but all timing and sequencing state restarts from its reset value.

Top module: `cps_port`

## Requirements
- R1: With divider codes `mdiv_code`=a and `sdiv_code`=b, where each code selects a ratio of 2^code (1, 2, 4 or 8), one `sclk` period lasts 2·2^a·2^b master clock cycles. A ratio of 1 passes the clock through to the next stage.
- R2: `sfs` is high for exactly one `sclk` period. That period immediately precedes the first data bit of each transmit word, and `sfs` changes only when `sclk` rises.
- R3: Each transmit word is sent as 16 bits, most significant first, one bit per `sclk` period with changes on the rising edge. `sdo_oe` is high during exactly those 16 periods and low otherwise.
- R4: A high `sdifs` sampled on a falling `sclk` edge starts a receive. The next 16 falling edges sample `sdi` most significant bit first. The assembled word then appears on `rx_word` with `rx_valid` high for one master clock cycle, and `rx_word` changes at no other time.
- R5: `tx_load` writes `tx_word` into the holding register and drops `tx_ready` in the following cycle. A word loaded during a transfer is sent directly after it, so the next frame sync period follows the previous last bit with no gap: frame sync pulses are 17 periods apart.
- R6: Within three master cycles of `port_en` going low, `sclk`, `sdo_oe`, `sfs_oe` and `sfs` are low. While disabled, activity on `sdi` and `sdifs` produces no `rx_valid`.
- R7: After a disable and re-enable, `rx_word` and a word waiting in the holding register keep their values; the held word is sent after re-enable. A word that was being shifted at the moment of the disable is discarded, and framing restarts cleanly.
- R8: While `rst_n` is low, `sclk`, `sdo_oe`, `sfs_oe`, `sfs` and `rx_valid` are 0, `rx_word` is 0 and `tx_ready` is 1; this also discards a held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Asynchronous port enable |
| mdiv_code | input | 2 | First divider code, ratio 2^code |
| sdiv_code | input | 2 | Second divider code, ratio 2^code |
| tx_word | input | 16 | Transmit word to load |
| tx_load | input | 1 | Load strobe for `tx_word` |
| tx_ready | output | 1 | Holding register empty |
| sdi | input | 1 | Serial data in |
| sdifs | input | 1 | Receive frame sync in |
| sclk | output | 1 | Derived serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| sfs | output | 1 | Transmit frame sync out |
| sfs_oe | output | 1 | Drive enable for `sfs` |
| rx_word | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe on word completion |

## Verification
Some properties hold every cycle and are checked by the assertions:
- `sclk` moves only on a divider tick.
- Transmit data and its drive enable change only on a rising `sclk` event.
- The transmit frame sync lasts a single period and hands over to data.
- The receive strobe is a single cycle, and the received word moves only on a falling event.
- A held word persists until it is sent or replaced.
- The port goes quiet one cycle after the synchronized enable drops.

The bench scenarios cover what only a whole transfer can show:
- the measured `sclk` period for several divider settings;
- the bit order of transmitted and received words;
- the 17-period spacing of back-to-back frames;
- the discarding of an interrupted word;
- the survival of held and received words across a disable.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SYNC = 2'd1,
    TX_DATA = 2'd2
  } tx_state_t;

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_BITS = 1'b1
  } rx_state_t;

  // Divide ratio selected by a divider code: 2^code.
  function automatic int unsigned ratio_of(input int unsigned code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/cps_clkgen.sv
module cps_clkgen import cps_pkg::*; #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] mdiv_code,
  input  logic [CODE_W-1:0] sdiv_code,
  output logic              sclk,
  output logic              rise_evt,
  output logic              fall_evt
);
  localparam int MAX_LOG = (1 << CODE_W) - 1;
  localparam int CNT_W   = (MAX_LOG < 1) ? 1 : MAX_LOG;

  logic [CNT_W-1:0] m_cnt, s_cnt, m_lim, s_lim;
  logic             m_tick, half_tick, sclk_q;

  assign m_lim     = CNT_W'(ratio_of(32'(mdiv_code)) - 32'd1);
  assign s_lim     = CNT_W'(ratio_of(32'(sdiv_code)) - 32'd1);
  assign m_tick    = en && (m_cnt >= m_lim);
  assign half_tick = m_tick && (s_cnt >= s_lim);
  assign rise_evt  = half_tick && !sclk_q;
  assign fall_evt  = half_tick && sclk_q;
  assign sclk      = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  <= '0;
      s_cnt  <= '0;
      sclk_q <= 1'b0;
    end else if (!en) begin
      m_cnt  <= '0;
      s_cnt  <= '0;
      sclk_q <= 1'b0;
    end else begin
      m_cnt <= m_tick ? '0 : m_cnt + 1'b1;
      if (m_tick) s_cnt <= half_tick ? '0 : s_cnt + 1'b1;
      if (half_tick) sclk_q <= ~sclk_q;
    end
  end

  a_r1_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !half_tick) |=> $stable(sclk_q))
    else $error("R1: sclk moved without a divider tick");

endmodule

// File: rtl/cps_tx.sv
module cps_tx import cps_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise_evt,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_ready,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sfs
);
  localparam int BIT_W = $clog2(WORD_W);

  tx_state_t         state;
  logic [WORD_W-1:0] hold_q, shreg;
  logic              hold_v, fs_q, oe_q, take, last_bit;
  logic [BIT_W-1:0]  bit_cnt;

  assign last_bit = (state == TX_DATA) && (bit_cnt == '0);
  assign take     = rise_evt && hold_v && ((state == TX_IDLE) || last_bit);
  assign tx_ready = !hold_v;
  assign sdo      = oe_q & shreg[WORD_W-1];
  assign sdo_oe   = oe_q;
  assign sfs      = fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hold_v  <= 1'b0;
      shreg   <= '0;
      state   <= TX_IDLE;
      fs_q    <= 1'b0;
      oe_q    <= 1'b0;
      bit_cnt <= '0;
    end else begin
      if (take) hold_v <= 1'b0;
      if (tx_load) begin
        hold_q <= tx_word;
        hold_v <= 1'b1;
      end
      if (!en) begin
        state   <= TX_IDLE;
        fs_q    <= 1'b0;
        oe_q    <= 1'b0;
        bit_cnt <= '0;
      end else if (rise_evt) begin
        if (take) begin
          shreg <= hold_q;
          state <= TX_SYNC;
          fs_q  <= 1'b1;
          oe_q  <= 1'b0;
        end else begin
          case (state)
            TX_SYNC: begin
              state   <= TX_DATA;
              fs_q    <= 1'b0;
              oe_q    <= 1'b1;
              bit_cnt <= BIT_W'(WORD_W - 1);
            end
            TX_DATA: begin
              if (last_bit) begin
                state <= TX_IDLE;
                oe_q  <= 1'b0;
              end else begin
                bit_cnt <= bit_cnt - 1'b1;
                shreg   <= {shreg[WORD_W-2:0], 1'b0};
              end
            end
            default: state <= TX_IDLE;
          endcase
        end
      end
    end
  end

  a_r2_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fs_q && rise_evt) |=> (!fs_q && oe_q))
    else $error("R2: frame sync not followed by data");

  a_r3_out_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rise_evt) |=> ($stable(oe_q) && $stable(sdo) && $stable(fs_q)))
    else $error("R3: serial output moved off a rising event");

  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !take && !tx_load) |=> (hold_v && $stable(hold_q)))
    else $error("R5: held word lost");

  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && hold_v && !tx_load) |=> hold_v)
    else $error("R7: held word lost while disabled");

endmodule

// File: rtl/cps_rx.sv
module cps_rx import cps_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fall_evt,
  input  logic              sdi,
  input  logic              sdifs,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int BIT_W = $clog2(WORD_W);

  rx_state_t         state;
  logic [WORD_W-2:0] shreg;
  logic [BIT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_HUNT;
      shreg    <= '0;
      cnt      <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else if (!en) begin
      state    <= RX_HUNT;
      cnt      <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fall_evt) begin
        case (state)
          RX_HUNT: if (sdifs) begin
            state <= RX_BITS;
            cnt   <= BIT_W'(WORD_W - 1);
          end
          RX_BITS: begin
            shreg <= {shreg[WORD_W-3:0], sdi};
            if (cnt == '0) begin
              rx_word  <= {shreg, sdi};
              rx_valid <= 1'b1;
              state    <= RX_HUNT;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: state <= RX_HUNT;
        endcase
      end
    end
  end

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid)
    else $error("R4: receive strobe longer than one cycle");

  a_r4_word_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(rx_word))
    else $error("R4: received word moved off a falling event");

endmodule

// File: rtl/cps_port.sv
module cps_port import cps_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 2
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [CODE_W-1:0] mdiv_code,
  input  logic [CODE_W-1:0] sdiv_code,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_load,
  output logic              tx_ready,
  input  logic              sdi,
  input  logic              sdifs,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sfs,
  output logic              sfs_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  logic en_meta, en_s;
  logic rise_evt, fall_evt;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      en_meta <= 1'b0;
      en_s    <= 1'b0;
    end else begin
      en_meta <= port_en;
      en_s    <= en_meta;
    end
  end

  assign sfs_oe = en_s;

  cps_clkgen #(.CODE_W(CODE_W)) u_clk (
    .clk(mclk), .rst_n(rst_n), .en(en_s),
    .mdiv_code(mdiv_code), .sdiv_code(sdiv_code),
    .sclk(sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  cps_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(mclk), .rst_n(rst_n), .en(en_s), .rise_evt(rise_evt),
    .tx_load(tx_load), .tx_word(tx_word), .tx_ready(tx_ready),
    .sdo(sdo), .sdo_oe(sdo_oe), .sfs(sfs)
  );

  cps_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(mclk), .rst_n(rst_n), .en(en_s), .fall_evt(fall_evt),
    .sdi(sdi), .sdifs(sdifs), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  a_r6_quiet_off: assert property (@(posedge mclk) disable iff (!rst_n)
    !en_s |=> (!sclk && !sdo_oe && !sfs && !rx_valid))
    else $error("R6: port active while disabled");

  a_r6_no_edges_off: assert property (@(posedge mclk) disable iff (!rst_n)
    !en_s |-> (!rise_evt && !fall_evt))
    else $error("R6: serial clock event while disabled");

endmodule

// File: tb/tb_cps_port.sv
module tb_cps_port;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b1;
  logic [1:0]  mdiv_code = 2'd0, sdiv_code = 2'd0;
  logic [15:0] tx_word = 16'h0;
  logic        tx_load = 1'b0;
  logic        sdi = 1'b0, sdifs = 1'b0;
  logic        tx_ready, sclk, sdo, sdo_oe, sfs, sfs_oe, rx_valid;
  logic [15:0] rx_word;

  int n_run = 0, n_fail = 0;
  logic [15:0] tx_q[$];
  logic [15:0] rx_q[$];

  logic        prev_sclk = 1'b0;
  bit          mon_en = 1'b1;
  bit          mon_active = 1'b0;
  int          mon_bits = 0;
  logic [15:0] mon_word = 16'h0;
  int          fall_cnt = 0, fs_last = 0, fs_prev = 0;
  int          cyc = 0;

  always #5 mclk = ~mclk;

  cps_port dut (
    .mclk(mclk), .rst_n(rst_n), .port_en(port_en),
    .mdiv_code(mdiv_code), .sdiv_code(sdiv_code),
    .tx_word(tx_word), .tx_load(tx_load), .tx_ready(tx_ready),
    .sdi(sdi), .sdifs(sdifs), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe),
    .sfs(sfs), .sfs_oe(sfs_oe), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Watchdog
  always @(posedge mclk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // Transmit monitor: host captures on falling sclk
  always @(negedge mclk) begin
    if (prev_sclk && !sclk && mon_en) begin
      fall_cnt++;
      if (mon_active) begin
        chk(sdo_oe == 1'b1, "R3 oe during data", int'(sdo_oe), 1);
        chk(sfs == 1'b0, "R2 fs one period", int'(sfs), 0);
        mon_word = {mon_word[14:0], sdo};
        mon_bits++;
        if (mon_bits == 16) begin
          mon_active = 1'b0;
          if (tx_q.size() == 0) chk(1'b0, "R3 unexpected word", int'(mon_word), 0);
          else begin
            logic [15:0] e;
            e = tx_q.pop_front();
            chk(mon_word == e, "R3 tx word", int'(mon_word), int'(e));
          end
        end
      end else if (sfs) begin
        chk(sfs_oe == 1'b1 && sdo_oe == 1'b0, "R2 fs drive", int'({sfs_oe, sdo_oe}), 2);
        mon_active = 1'b1;
        mon_bits = 0;
        fs_prev = fs_last;
        fs_last = fall_cnt;
      end else begin
        chk(sdo_oe == 1'b0, "R3 oe idle", int'(sdo_oe), 0);
      end
    end
    prev_sclk = sclk;
  end

  // Receive monitor
  always @(negedge mclk) begin
    if (rst_n && rx_valid) begin
      if (rx_q.size() == 0) chk(1'b0, "R4 unexpected rx", int'(rx_word), 0);
      else begin
        logic [15:0] e;
        e = rx_q.pop_front();
        chk(rx_word == e, "R4 rx word", int'(rx_word), int'(e));
      end
    end
  end

  task automatic wait_rise();
    logic last;
    do begin
      last = sclk;
      @(negedge mclk);
    end while (!(sclk && !last));
  endtask

  task automatic send_rx(input logic [15:0] w);
    rx_q.push_back(w);
    wait_rise(); sdifs = 1'b1;
    wait_rise(); sdifs = 1'b0; sdi = w[15];
    for (int i = 14; i >= 0; i--) begin
      wait_rise(); sdi = w[i];
    end
    wait_rise(); sdi = 1'b0;
  endtask

  task automatic load_tx(input logic [15:0] w, input bit expect_send);
    if (expect_send) tx_q.push_back(w);
    tx_word = w; tx_load = 1'b1;
    @(negedge mclk);
    tx_load = 1'b0;
    chk(tx_ready == 1'b0, "R5 ready drops", int'(tx_ready), 0);
  endtask

  task automatic drain();
    int n = 0;
    while ((tx_q.size() != 0 || rx_q.size() != 0 || mon_active) && n < 20000) begin
      @(negedge mclk); n++;
    end
    chk(tx_q.size() == 0 && rx_q.size() == 0, "R3 R4 drained", tx_q.size() + rx_q.size(), 0);
  endtask

  task automatic restart(input logic [1:0] a, input logic [1:0] b);
    port_en = 1'b0;
    repeat (4) @(negedge mclk);
    mdiv_code = a; sdiv_code = b;
    port_en = 1'b1;
    repeat (4) @(negedge mclk);
  endtask

  task automatic meas(input logic [1:0] a, input logic [1:0] b);
    int t0, t1, exp;
    mon_en = 1'b0;
    restart(a, b);
    mon_en = 1'b1;
    wait_rise(); t0 = cyc;
    wait_rise(); t1 = cyc;
    exp = 2 << (int'(a) + int'(b));
    chk((t1 - t0) == exp, "R1 sclk period", t1 - t0, exp);
  endtask

  initial begin
    repeat (3) @(negedge mclk);
    // R8 reset state
    chk(sclk == 0 && sdo_oe == 0 && sfs_oe == 0 && sfs == 0 && rx_valid == 0,
        "R8 reset outputs", int'({sclk, sdo_oe, sfs_oe, sfs, rx_valid}), 0);
    chk(rx_word == 16'h0 && tx_ready == 1'b1, "R8 reset regs", int'(rx_word), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge mclk);

    // R1 periods
    meas(2'd0, 2'd0);
    meas(2'd2, 2'd0);
    meas(2'd1, 2'd2);
    meas(2'd3, 2'd3);

    // R3 R4 transfers at fastest setting and a slower one
    meas(2'd0, 2'd0);
    fork
      load_tx(16'hA5C3, 1'b1);
      send_rx(16'h8001);
    join
    drain();
    fork
      load_tx(16'h0000, 1'b1);
      send_rx(16'hFFFF);
    join
    drain();
    meas(2'd1, 2'd1);
    fork
      load_tx(16'h7E18, 1'b1);
      send_rx(16'h3C5A);
    join
    drain();

    // R5 back-to-back words: frames 17 periods apart
    meas(2'd0, 2'd0);
    load_tx(16'h1234, 1'b1);
    while (!tx_ready) @(negedge mclk);
    load_tx(16'hFEDC, 1'b1);
    drain();
    chk((fs_last - fs_prev) == 17, "R5 frame spacing", fs_last - fs_prev, 17);

    // R6 R7 disable mid-word
    send_rx(16'hC0DE);
    drain();
    load_tx(16'hDEAD, 1'b0);
    while (!(mon_active && mon_bits >= 5)) @(negedge mclk);
    #1;
    mon_en = 1'b0; mon_active = 1'b0;
    port_en = 1'b0;
    repeat (3) @(negedge mclk);
    for (int i = 0; i < 40; i++) begin
      sdi = i[0]; sdifs = i[1];
      @(negedge mclk);
      chk(sclk == 0 && sdo_oe == 0 && sfs_oe == 0 && sfs == 0,
          "R6 quiet while off", int'({sclk, sdo_oe, sfs_oe, sfs}), 0);
      chk(rx_valid == 1'b0, "R6 inputs ignored", int'(rx_valid), 0);
    end
    sdi = 1'b0; sdifs = 1'b0;
    chk(rx_word == 16'hC0DE, "R7 rx word kept", int'(rx_word), 16'hC0DE);
    load_tx(16'hBEEF, 1'b1);
    repeat (10) @(negedge mclk);
    chk(tx_ready == 1'b0, "R7 hold kept while off", int'(tx_ready), 0);
    mon_en = 1'b1;
    port_en = 1'b1;
    drain();
    send_rx(16'h5AA5);
    drain();

    // R8 reset clears held word and received word
    port_en = 1'b0;
    repeat (4) @(negedge mclk);
    load_tx(16'h4321, 1'b0);
    rst_n = 1'b0;
    @(negedge mclk);
    chk(tx_ready == 1'b1 && rx_word == 16'h0, "R8 reset clears", int'(rx_word), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge mclk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule